// File: doc/BRIEF.md
# Timebase and Decrementer Timer

This block keeps two time counters that run from the core clock. A 64-bit timebase counts up freely, one step for every four core clocks, and is read as an upper and a lower 32-bit half. A 32-bit decrementer counts down, one step for every 2 × BUS_MULT core clocks. BUS_MULT is the bus-frequency multiplier, a parameter of at least 1. Each counter has its own prescaler.

Software can load the decrementer and either half of the timebase through write strobes that share one data bus. A load restarts the prescaler of the counter it writes. The prescaler of the other counter keeps its partial count, so the remainder toward the next tick is not lost.

When a decrement takes the decrementer from 0 to 0xFFFF_FFFF, the block raises a request that is high for exactly one cycle. The exception controller downstream latches this request and applies its own masking and vectoring.

Top module: `tbdec_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the timebase reads 0, the decrementer reads 0xFFFF_FFFF and the interrupt request is low.
- R2: With no timebase write, the 64-bit timebase advances by exactly one on every fourth rising clock edge, counted from reset or from the last timebase write.
- R3: The timebase is one 64-bit count. The lower half (bits 31:0) wrapping from 0xFFFF_FFFF to 0 carries into the upper half (bits 63:32), and the full value wraps to zero.
- R4: With no decrementer write, the decrementer falls by exactly one on every (2 × BUS_MULT)-th rising edge, counted from reset or from the last decrementer write.
- R5: A decrementer write loads the data at that edge and restarts its prescaler, so the first decrement after it comes 2 × BUS_MULT edges later.
- R6: A write to the upper or lower timebase half loads that half at that edge. The other half is left unchanged, no increment happens at that edge, and the timebase prescaler restarts.
- R7: Timebase writes leave the decrementer value and its partial prescaler count untouched. Decrementer writes leave the timebase value and its prescaler untouched.
- R8: The interrupt request is high for exactly the one cycle after the edge at which the decrementer stepped from 0 to 0xFFFF_FFFF. It is low at every other time.
- R9: A decrementer write at the same edge as a decrementer tick wins over the tick. The written value appears unchanged and no interrupt request is raised, even if the old value was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_hi_we | input | 1 | Load timebase bits 63:32 from wdata |
| tb_lo_we | input | 1 | Load timebase bits 31:0 from wdata |
| dec_we | input | 1 | Load decrementer from wdata |
| wdata | input | 32 | Write data shared by the three strobes |
| tb_hi | output | 32 | Timebase bits 63:32 |
| tb_lo | output | 32 | Timebase bits 31:0 |
| dec_value | output | 32 | Current decrementer value |
| dec_irq | output | 1 | One-cycle decrementer wrap request |

## Verification
The assertions assume that BUS_MULT is at least 1, so that two interrupt requests are always at least two cycles apart. They also assume that the write strobes are synchronous levels that are low whenever no load is wanted. The stimulus raises one strobe at a time, for a single cycle, between falling edges. It writes the timebase in the middle of a decrementer period and the decrementer in the middle of a timebase period. It also places one decrementer write exactly on a pending wrap tick. The same stimulus drives two instances, built with BUS_MULT of 1 and 3, so the tick spacing is checked for both dividers.

// File: rtl/tbdec_timer.sv
module tbdec_timer #(
  parameter int W        = 32,
  parameter int BUS_MULT = 2,
  parameter int TB_DIV   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tb_hi_we,
  input  logic         tb_lo_we,
  input  logic         dec_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tb_hi,
  output logic [W-1:0] tb_lo,
  output logic [W-1:0] dec_value,
  output logic         dec_irq
);
  localparam int MULT    = (BUS_MULT < 1) ? 1 : BUS_MULT;
  localparam int DEC_DIV = 2 * MULT;
  localparam int TPW     = $clog2(TB_DIV + 1);
  localparam int DPW     = $clog2(DEC_DIV + 1);

  logic [2*W-1:0] tb_q;
  logic [TPW-1:0] tb_pre;
  logic [W-1:0]   dec_q;
  logic [DPW-1:0] dec_pre;
  logic           irq_q;

  logic tb_wr, tb_tick, dec_tick;
  assign tb_wr    = tb_hi_we | tb_lo_we;
  assign tb_tick  = (tb_pre == TPW'(TB_DIV - 1));
  assign dec_tick = (dec_pre == DPW'(DEC_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q   <= '0;
      tb_pre <= '0;
    end else if (tb_wr) begin
      tb_pre <= '0;
      if (tb_hi_we) tb_q[2*W-1:W] <= wdata;
      if (tb_lo_we) tb_q[W-1:0]   <= wdata;
    end else if (tb_tick) begin
      tb_pre <= '0;
      tb_q   <= tb_q + 1'b1;
    end else begin
      tb_pre <= tb_pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= '1;
      dec_pre <= '0;
      irq_q   <= 1'b0;
    end else if (dec_we) begin
      dec_q   <= wdata;
      dec_pre <= '0;
      irq_q   <= 1'b0;
    end else if (dec_tick) begin
      dec_pre <= '0;
      dec_q   <= dec_q - 1'b1;
      irq_q   <= (dec_q == '0);
    end else begin
      dec_pre <= dec_pre + 1'b1;
      irq_q   <= 1'b0;
    end
  end

  assign tb_hi     = tb_q[2*W-1:W];
  assign tb_lo     = tb_q[W-1:0];
  assign dec_value = dec_q;
  assign dec_irq   = irq_q;
endmodule

module tbdec_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tb_hi_we,
  input logic         tb_lo_we,
  input logic         dec_we,
  input logic [W-1:0] wdata,
  input logic [W-1:0] tb_hi,
  input logic [W-1:0] tb_lo,
  input logic [W-1:0] dec_value,
  input logic         dec_irq
);
  logic [2*W-1:0] tb_all;
  assign tb_all = {tb_hi, tb_lo};

  a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_hi_we && !tb_lo_we) |=> (tb_all == $past(tb_all) || tb_all == $past(tb_all) + 1'b1));

  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_we |=> (dec_value == $past(dec_value) || dec_value == $past(dec_value) - 1'b1));

  a_r5_dec_load: assert property (@(posedge clk) disable iff (!rst_n)
    dec_we |=> (dec_value == $past(wdata) && !dec_irq));

  a_r6_tb_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    tb_hi_we |=> tb_hi == $past(wdata));

  a_r6_tb_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_lo_we && !tb_hi_we) |=> (tb_lo == $past(wdata) && tb_hi == $past(tb_hi)));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |=> !dec_irq);

  a_r8_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dec_irq |-> (dec_value == '1 && $past(dec_value) == '0));
endmodule

bind tbdec_timer tbdec_timer_chk #(.W(W)) u_chk (.*);

// File: tb/sim_tbdec_timer.sv
`timescale 1ns/1ps
module sim_tbdec_timer;
  localparam int MA = 1;
  localparam int MB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_hi_we = 1'b0, tb_lo_we = 1'b0, dec_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] hi_a, lo_a, dv_a, hi_b, lo_b, dv_b;
  logic irq_a, irq_b;

  always #5 clk = ~clk;

  tbdec_timer #(.W(32), .BUS_MULT(MA)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_hi_we(tb_hi_we), .tb_lo_we(tb_lo_we),
    .dec_we(dec_we), .wdata(wdata), .tb_hi(hi_a), .tb_lo(lo_a),
    .dec_value(dv_a), .dec_irq(irq_a));

  tbdec_timer #(.W(32), .BUS_MULT(MB)) u1 (
    .clk(clk), .rst_n(rst_n), .tb_hi_we(tb_hi_we), .tb_lo_we(tb_lo_we),
    .dec_we(dec_we), .wdata(wdata), .tb_hi(hi_b), .tb_lo(lo_b),
    .dec_value(dv_b), .dec_irq(irq_b));

  int checks = 0, fails = 0;
  int cyc = 0, dw = 0, tw = 0;
  logic [31:0] dv0 = 32'hFFFF_FFFF;
  logic [63:0] tb0 = '0;
  logic chk_en = 1'b0;
  string req = "R2";

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic logic [63:0] tb_exp();
    return tb0 + 64'((cyc - tw) / 4);
  endfunction

  function automatic logic [31:0] dec_exp(int d);
    return dv0 - 32'((cyc - dw) / d);
  endfunction

  function automatic logic irq_exp(int d);
    int n = cyc - dw;
    return (n > 0) && (n % d == 0) && ((dv0 - 32'(n / d)) == 32'hFFFF_FFFF);
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cyc=%0d actual=%h expected=%h", r, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    chk(req, "u0 timebase", {hi_a, lo_a}, tb_exp());
    chk(req, "u1 timebase", {hi_b, lo_b}, tb_exp());
    chk(req, "u0 decrementer", 64'(dv_a), 64'(dec_exp(2*MA)));
    chk(req, "u1 decrementer", 64'(dv_b), 64'(dec_exp(2*MB)));
    chk(req, "u0 irq", 64'(irq_a), 64'(irq_exp(2*MA)));
    chk(req, "u1 irq", 64'(irq_b), 64'(irq_exp(2*MB)));
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 = decrementer, 1 = timebase upper half, 2 = timebase lower half
  task automatic wr(int kind, logic [31:0] d);
    logic [63:0] old;
    @(negedge clk);
    old = tb_exp();
    wdata = d;
    dec_we = (kind == 0);
    tb_hi_we = (kind == 1);
    tb_lo_we = (kind == 2);
    @(posedge clk);
    #1;
    if (kind == 0) begin dv0 = d; dw = cyc; end
    if (kind == 1) begin tb0 = {d, old[31:0]}; tw = cyc; end
    if (kind == 2) begin tb0 = {old[63:32], d}; tw = cyc; end
    dec_we = 1'b0; tb_hi_we = 1'b0; tb_lo_we = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "u0 timebase", {hi_a, lo_a}, 64'd0);
    chk("R1", "u1 timebase", {hi_b, lo_b}, 64'd0);
    chk("R1", "u0 decrementer", 64'(dv_a), 64'hFFFF_FFFF);
    chk("R1", "u1 decrementer", 64'(dv_b), 64'hFFFF_FFFF);
    chk("R1", "u0 irq", 64'(irq_a), 64'd0);
    chk("R1", "u1 irq", 64'(irq_b), 64'd0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    // R2 and R4: free-running ticks from reset
    req = "R2"; run(60);
    // R5: a load restarts the decrementer prescaler
    req = "R5"; run(1); wr(0, 32'd3); run(40);
    // R8: wrap from zero raises a one-cycle request
    req = "R8"; wr(0, 32'd0); run(20);
    // R3: carry from the lower half into the upper half, then a full 64-bit wrap
    req = "R3"; wr(2, 32'hFFFF_FFF0); run(80);
    wr(1, 32'hFFFF_FFFF); run(1); wr(2, 32'hFFFF_FFFE); run(20);
    // R6: half writes in the middle of a prescaler period
    req = "R6"; run(2); wr(1, 32'h1234_5678); run(6); wr(2, 32'h0000_0ABC); run(10);
    // R7: cross writes keep the other counter's value and remainder
    req = "R7"; wr(0, 32'd100); run(3); wr(2, 32'd0); run(1); wr(1, 32'd7); run(30);
    run(1); wr(0, 32'd40); run(25);
    // R9: a load at the same edge as a pending wrap tick wins
    req = "R9"; wr(0, 32'd0); run(5); wr(0, 32'd5); run(40);
    // R4 and R8: sweep small reload values for both dividers
    for (int v = 0; v < 8; v++) begin
      req = "R4"; wr(0, 32'(v)); run(2*MB*(v+1) + 7);
    end
    req = "R4"; wr(0, 32'd20); run(1500);
    chk_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule